// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Instruction Decode

This block is the serial test port of a small configuration memory. It follows the usual four-wire test-port protocol. TMS steps a sixteen-state controller on each rising TCK edge. Instruction and data bits enter on TDI and leave on TDO, least significant bit first. An 8-bit instruction register picks the data path that sits between TDI and TDO. The choices are a one-bit pass-through stage, a 32-bit word register that loads either the device identifier or a user word, and an external boundary cell chain, which lives outside this block.

Beyond the path choice, the decoded instruction drives four things. It raises a flag that tells the pin cells to drive from their update latches (external test and clamp). It raises a clamp flag and a float-all-outputs flag. It also issues a single active-low configuration request. That request is one TCK cycle long and fires after a configuration opcode is loaded. When the instruction register is captured, it loads a fixed marker pattern together with two live status inputs, so a host can read device state during every instruction scan.

Top module: `jtag_tap_port`

## Requirements
- R1: The controller enters Test-Logic-Reset when `trst_n` is low at a rising TCK edge. It also gets there after five consecutive rising edges with TMS high, from any state.
- R2: Reset, by either route, makes the identifier instruction (0xFE) current, or the pass-through instruction when `HAS_ID` is 0. Reset leaves `tdo_oe` low, `cfg_n` high and every mode flag low.
- R3: In Capture-IR the instruction shifter loads a fixed pattern, which is shifted out LSB first. Bits 1:0 are 01, bit 2 is 0, bit 3 is `sec_flag`, bit 4 is `isc_flag`, and bits 7:5 are 0.
- R4: A newly shifted opcode does not change the current instruction, or any mode output, until the controller passes through Update-IR.
- R5: Opcode 0xFF, and every opcode not listed in R6 to R10, selects the one-bit pass-through stage. That stage captures 0, so TDO repeats TDI one shift later.
- R6: Opcode 0xFE shifts out the 32-bit `ID_VALUE` and opcode 0xFD shifts out the 32-bit `USER_VALUE`, both LSB first.
- R7: Opcodes 0x01 (sample) and 0x00 (external test) route TDO from `chain_tdo` and pulse the chain capture, shift and update strobes in the matching data-scan states. Only 0x00 also raises `drive_from_latch`.
- R8: Opcode 0xFA raises `clamp_en` and `drive_from_latch`, and selects the pass-through stage.
- R9: Opcode 0xFC raises `highz_en` and selects the pass-through stage.
- R10: After opcode 0xEE is loaded, `cfg_n` goes low for exactly one TCK cycle, on the first entry to Run-Test/Idle. It stays high on later entries until 0xEE is loaded again. The pass-through stage is the data path.
- R11: TDO and `tdo_oe` change only on falling TCK edges. `tdo_oe` is high only while the controller is in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, sampled on the rising TCK edge |
| tms | input | 1 | Mode select that steps the controller |
| tdi | input | 1 | Serial data in |
| sec_flag | input | 1 | Security status, captured into bit 3 of the instruction shifter |
| isc_flag | input | 1 | Programming status, captured into bit 4 of the instruction shifter |
| chain_tdo | input | 1 | Serial output of the external boundary cell chain |
| tdo | output | 1 | Serial data out, valid when `tdo_oe` is high |
| tdo_oe | output | 1 | Output enable for the TDO pad |
| cfg_n | output | 1 | One-cycle active-low configuration request |
| clamp_en | output | 1 | Clamp instruction is current |
| highz_en | output | 1 | Float-all-outputs instruction is current |
| drive_from_latch | output | 1 | Pins take their values from the chain update latches |
| chain_capture | output | 1 | Chain is selected and the controller is in Capture-DR |
| chain_shift | output | 1 | Chain is selected and the controller is in Shift-DR |
| chain_update | output | 1 | Chain is selected and the controller is in Update-DR |

## Verification
Some properties are checked by assertions on every rising edge:
- the reset routes into Test-Logic-Reset,
- the fixed bits of the captured instruction pattern,
- that the current instruction changes only in Update-IR or reset,
- the one-cycle width of the configuration request and that it lies in Run-Test/Idle,
- that `tdo_oe` follows the shift states,
- that clamp, float and chain shifting never overlap.

Other properties need full scans, so only the directed scenarios show them:
- the serial values on TDO (identifier, user word, pass-through delay, captured status bits),
- how undefined opcodes decode,
- that TDO moves on the falling edge rather than the rising edge,
- that the configuration request does not repeat until the opcode is loaded again.

// File: rtl/jtag_tap_pkg.sv
// Package: shared types for the test access port.
// Holds the controller state encoding, the opcode values, the decoded
// instruction record and the next-state function used by the controller.
package jtag_tap_pkg;

    localparam int IR_W = 8;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR,
        ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_EXTEST = 8'h00;
    localparam logic [IR_W-1:0] OP_SAMPLE = 8'h01;
    localparam logic [IR_W-1:0] OP_CLAMP  = 8'hFA;
    localparam logic [IR_W-1:0] OP_HIGHZ  = 8'hFC;
    localparam logic [IR_W-1:0] OP_USER   = 8'hFD;
    localparam logic [IR_W-1:0] OP_IDENT  = 8'hFE;
    localparam logic [IR_W-1:0] OP_CONFIG = 8'hEE;
    localparam logic [IR_W-1:0] OP_BYPASS = 8'hFF;

    typedef enum logic [1:0] {SRC_PASS, SRC_WORD, SRC_CHAIN} dr_src_e;

    typedef struct packed {
        dr_src_e src;
        logic    word_is_user;
        logic    chain_drive;
        logic    clamp;
        logic    highz;
    } tap_decode_t;

    // Controller successor state for a given TMS value.
    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        tap_state_e n;
        case (s)
            ST_TLR:    n = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    n = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PA_DR;
            ST_PA_DR:  n = tms ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: n = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PA_IR;
            ST_PA_IR:  n = tms ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = tms ? ST_SEL_DR : ST_RTI;
            default:   n = ST_TLR;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
// Module: sixteen-state test port controller.
// Assumes trst_n is synchronous to tck. Exposes the present state and the
// state that the next rising edge will load.
module jtag_tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state,
    output tap_state_e state_nxt
);

    // Successor state for the current TMS value.
    always_comb state_nxt = tap_next(state, tms);

    // State register with synchronous reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_TLR;
        else         state <= state_nxt;
    end

endmodule

// File: rtl/jtag_tap_ir.sv
// Module: instruction shifter, current instruction, decode and the
// configuration request pulse. Assumes the controller state is registered
// on the same tck edge. Undefined opcodes decode as pass-through.
module jtag_tap_ir
    import jtag_tap_pkg::*;
#(
    parameter bit HAS_ID = 1'b1
) (
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state,
    input  tap_state_e      state_nxt,
    input  logic            tdi,
    input  logic            sec_flag,
    input  logic            isc_flag,
    output logic [IR_W-1:0] ir_sh,
    output logic [IR_W-1:0] instr,
    output tap_decode_t     dec,
    output logic            cfg_n
);

    localparam logic [IR_W-1:0] RESET_OP = HAS_ID ? OP_IDENT : OP_BYPASS;

    logic [IR_W-1:0] cap_val;
    logic            armed, armed_pre, fire;

    // Status pattern loaded during Capture-IR.
    always_comb cap_val = {3'b000, isc_flag, sec_flag, 1'b0, 2'b01};

    // Instruction shifter: capture status, then shift towards TDO.
    always_ff @(posedge tck) begin
        if (!trst_n)                ir_sh <= '0;
        else if (state == ST_CAP_IR) ir_sh <= cap_val;
        else if (state == ST_SH_IR)  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end

    // Current instruction: reset value in Test-Logic-Reset, new value on Update-IR.
    always_ff @(posedge tck) begin
        if (!trst_n || state == ST_TLR) instr <= RESET_OP;
        else if (state == ST_UPD_IR)    instr <= ir_sh;
    end

    // Request pulse fires on the first entry to Run-Test/Idle after a config load.
    always_comb begin
        armed_pre = (state == ST_UPD_IR) ? (ir_sh == OP_CONFIG) : armed;
        fire      = armed_pre && (state_nxt == ST_RTI) && (state != ST_RTI);
    end

    // Pulse arming flag and registered active-low request.
    always_ff @(posedge tck) begin
        if (!trst_n || state == ST_TLR) begin
            armed <= 1'b0;
            cfg_n <= 1'b1;
        end else begin
            armed <= armed_pre && !fire;
            cfg_n <= !fire;
        end
    end

    // Opcode decode; anything not listed selects pass-through.
    always_comb begin
        dec = '{src: SRC_PASS, word_is_user: 1'b0, chain_drive: 1'b0, clamp: 1'b0, highz: 1'b0};
        case (instr)
            OP_EXTEST: begin dec.src = SRC_CHAIN; dec.chain_drive = 1'b1; end
            OP_SAMPLE: dec.src = SRC_CHAIN;
            OP_CLAMP:  begin dec.clamp = 1'b1; dec.chain_drive = 1'b1; end
            OP_HIGHZ:  dec.highz = 1'b1;
            OP_IDENT:  if (HAS_ID) dec.src = SRC_WORD;
            OP_USER:   begin dec.src = SRC_WORD; dec.word_is_user = 1'b1; end
            default:   ;
        endcase
    end

endmodule

// File: rtl/jtag_tap_dr.sv
// Module: data registers and TDO retiming. Holds the one-bit pass-through
// stage and the shared identifier/user word, muxes the serial source and
// re-times TDO and its enable onto the falling tck edge.
module jtag_tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int          WORD_W     = 32,
    parameter logic [31:0] ID_VALUE   = 32'h1A5C_3D15,
    parameter logic [31:0] USER_VALUE = 32'h5EED_C0DE
) (
    input  logic        tck,
    input  logic        trst_n,
    input  tap_state_e  state,
    input  tap_decode_t dec,
    input  logic        tdi,
    input  logic        ir_lsb,
    input  logic        chain_tdo,
    output logic        tdo,
    output logic        tdo_oe,
    output logic        chain_capture,
    output logic        chain_shift,
    output logic        chain_update
);

    localparam logic [WORD_W-1:0] ID_W_VAL   = WORD_W'(ID_VALUE);
    localparam logic [WORD_W-1:0] USER_W_VAL = WORD_W'(USER_VALUE);

    logic              pass_q;
    logic [WORD_W-1:0] word_q;
    logic              ser_bit;
    logic              chain_sel;

    always_comb chain_sel = (dec.src == SRC_CHAIN);

    // Strobes for the external cell chain.
    always_comb begin
        chain_capture = chain_sel && (state == ST_CAP_DR);
        chain_shift   = chain_sel && (state == ST_SH_DR);
        chain_update  = chain_sel && (state == ST_UPD_DR);
    end

    // Pass-through stage: captures 0, shifts TDI.
    always_ff @(posedge tck) begin
        if (!trst_n)                 pass_q <= 1'b0;
        else if (state == ST_CAP_DR) pass_q <= 1'b0;
        else if (state == ST_SH_DR)  pass_q <= tdi;
    end

    // Identifier/user word: load on capture when selected, shift towards TDO.
    always_ff @(posedge tck) begin
        if (!trst_n) word_q <= '0;
        else if (dec.src == SRC_WORD && state == ST_CAP_DR)
            word_q <= dec.word_is_user ? USER_W_VAL : ID_W_VAL;
        else if (dec.src == SRC_WORD && state == ST_SH_DR)
            word_q <= {tdi, word_q[WORD_W-1:1]};
    end

    // Serial source for the current scan.
    always_comb begin
        if (state == ST_SH_IR) ser_bit = ir_lsb;
        else begin
            case (dec.src)
                SRC_WORD:  ser_bit = word_q[0];
                SRC_CHAIN: ser_bit = chain_tdo;
                default:   ser_bit = pass_q;
            endcase
        end
    end

    // Falling-edge retiming of TDO and its enable.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= ser_bit;
            tdo_oe <= (state == ST_SH_DR) || (state == ST_SH_IR);
        end
    end

endmodule

// File: rtl/jtag_tap_port.sv
// Module: top of the test access port. Wires the controller, the
// instruction path and the data path, and brings the mode flags out.
// Assumes all inputs are synchronous to tck.
module jtag_tap_port
    import jtag_tap_pkg::*;
#(
    parameter bit          HAS_ID     = 1'b1,
    parameter int          WORD_W     = 32,
    parameter logic [31:0] ID_VALUE   = 32'h1A5C_3D15,
    parameter logic [31:0] USER_VALUE = 32'h5EED_C0DE
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    input  logic sec_flag,
    input  logic isc_flag,
    input  logic chain_tdo,
    output logic tdo,
    output logic tdo_oe,
    output logic cfg_n,
    output logic clamp_en,
    output logic highz_en,
    output logic drive_from_latch,
    output logic chain_capture,
    output logic chain_shift,
    output logic chain_update
);

    tap_state_e      state_q, state_nxt;
    logic [IR_W-1:0] ir_sh_q, instr_q;
    tap_decode_t     dec;

    jtag_tap_fsm fsm_i (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state_q), .state_nxt(state_nxt)
    );

    jtag_tap_ir #(.HAS_ID(HAS_ID)) ir_i (
        .tck(tck), .trst_n(trst_n), .state(state_q), .state_nxt(state_nxt), .tdi(tdi),
        .sec_flag(sec_flag), .isc_flag(isc_flag), .ir_sh(ir_sh_q), .instr(instr_q),
        .dec(dec), .cfg_n(cfg_n)
    );

    jtag_tap_dr #(.WORD_W(WORD_W), .ID_VALUE(ID_VALUE), .USER_VALUE(USER_VALUE)) dr_i (
        .tck(tck), .trst_n(trst_n), .state(state_q), .dec(dec), .tdi(tdi),
        .ir_lsb(ir_sh_q[0]), .chain_tdo(chain_tdo), .tdo(tdo), .tdo_oe(tdo_oe),
        .chain_capture(chain_capture), .chain_shift(chain_shift), .chain_update(chain_update)
    );

    // Mode flags straight from the decode.
    always_comb begin
        clamp_en         = dec.clamp;
        highz_en         = dec.highz;
        drive_from_latch = dec.chain_drive;
    end

endmodule

// File: rtl/jtag_tap_port_chk.sv
// Module: property checker for jtag_tap_port, attached by bind.
// Observes ports and the controller/instruction state of the top.
module jtag_tap_port_chk
    import jtag_tap_pkg::*;
(
    input logic            tck,
    input logic            trst_n,
    input logic            tms,
    input logic            tdo_oe,
    input logic            cfg_n,
    input logic            clamp_en,
    input logic            highz_en,
    input logic            chain_shift,
    input tap_state_e      state,
    input logic [IR_W-1:0] instr,
    input logic [IR_W-1:0] ir_sh
);

    p_trst_r1: assert property (@(posedge tck) !trst_n |=> state == ST_TLR);

    p_tms_reset_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> state == ST_TLR);

    p_capture_pattern_r3: assert property (@(posedge tck) disable iff (!trst_n)
        state == ST_CAP_IR |=> (ir_sh[2:0] == 3'b001 && ir_sh[7:5] == 3'b000));

    p_instr_hold_r4: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_UPD_IR && state != ST_TLR) |=> $stable(instr));

    p_modes_apart_r8: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({clamp_en, highz_en, chain_shift}));

    p_cfg_width_r10: assert property (@(posedge tck) disable iff (!trst_n)
        !cfg_n |=> cfg_n);

    p_cfg_idle_r10: assert property (@(posedge tck) disable iff (!trst_n)
        !cfg_n |-> state == ST_RTI);

    p_oe_shift_r11: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_SH_DR || state == ST_SH_IR) |-> tdo_oe);

    p_oe_idle_r11: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_SH_DR && state != ST_SH_IR) |-> !tdo_oe);

endmodule

bind jtag_tap_port jtag_tap_port_chk chk_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdo_oe(tdo_oe), .cfg_n(cfg_n),
    .clamp_en(clamp_en), .highz_en(highz_en), .chain_shift(chain_shift),
    .state(state_q), .instr(instr_q), .ir_sh(ir_sh_q)
);

// File: tb/jtag_tap_port_tb_top.sv
// Directed bench for jtag_tap_port: one task per scenario, port-level checks only.
module jtag_tap_port_tb_top;

    localparam logic [31:0] ID_V   = 32'h1A5C_3D15;
    localparam logic [31:0] USER_V = 32'h5EED_C0DE;

    logic tck = 1'b0;
    logic trst_n, tms, tdi, sec_flag, isc_flag, chain_tdo;
    logic tdo, tdo_oe, cfg_n, clamp_en, highz_en, drive_from_latch;
    logic chain_capture, chain_shift, chain_update;

    int n_chk = 0;
    int n_err = 0;

    always #2 tck = ~tck;

    jtag_tap_port #(.ID_VALUE(ID_V), .USER_VALUE(USER_V)) dut_i (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .sec_flag(sec_flag),
        .isc_flag(isc_flag), .chain_tdo(chain_tdo), .tdo(tdo), .tdo_oe(tdo_oe),
        .cfg_n(cfg_n), .clamp_en(clamp_en), .highz_en(highz_en),
        .drive_from_latch(drive_from_latch), .chain_capture(chain_capture),
        .chain_shift(chain_shift), .chain_update(chain_update)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One TCK cycle; returns just after the falling edge.
    task automatic step(input logic m, input logic d);
        tms = m; tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic shift_bits(input int n, input logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            step(i == n - 1, din[i]);
        end
    endtask

    task automatic to_shift_dr(); step(1, 0); step(0, 0); step(0, 0); endtask
    task automatic to_shift_ir(); step(1, 0); step(1, 0); step(0, 0); step(0, 0); endtask
    task automatic finish_scan(); step(1, 0); step(0, 0); endtask

    task automatic load_ir(input logic [7:0] op);
        logic [63:0] cap;
        to_shift_ir();
        shift_bits(8, {56'd0, op}, cap);
        finish_scan();
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        to_shift_dr();
        shift_bits(n, din, dout);
        finish_scan();
    endtask

    task automatic t_reset();
        logic [63:0] d;
        trst_n = 0; tms = 1; tdi = 0;
        repeat (3) step(1, 0);
        trst_n = 1;
        step(1, 0);
        chk("R2 tdo_oe after reset", tdo_oe, 0);
        chk("R2 cfg_n after reset", cfg_n, 1);
        chk("R2 modes after reset", {clamp_en, highz_en, drive_from_latch}, 0);
        step(0, 0);
        scan_dr(32, 0, d);
        chk("R2 reset instruction is identifier", d[31:0], ID_V);
    endtask

    task automatic t_tms_reset();
        logic [63:0] d, cap;
        load_ir(8'hFA);
        chk("R1 clamp loaded", clamp_en, 1);
        to_shift_ir();
        shift_bits(4, 0, cap);
        repeat (5) step(1, 0);
        chk("R1 five tms high clears modes", {clamp_en, drive_from_latch}, 0);
        step(0, 0);
        scan_dr(32, 0, d);
        chk("R1 identifier after tms reset", d[31:0], ID_V);
    endtask

    task automatic t_capture_ir();
        logic [63:0] cap;
        for (int k = 0; k < 2; k++) begin
            sec_flag = (k == 0); isc_flag = (k == 1);
            to_shift_ir();
            shift_bits(8, 64'hFF, cap);
            finish_scan();
            chk("R3 capture pattern", cap[7:0], {3'b000, isc_flag, sec_flag, 3'b001});
        end
    endtask

    task automatic t_bypass(input logic [7:0] op);
        logic [63:0] d;
        logic [63:0] pat = 64'hB6;
        load_ir(op);
        scan_dr(9, pat, d);
        chk("R5 pass-through output", d[8:0], {pat[7:0], 1'b0});
    endtask

    task automatic t_user();
        logic [63:0] d;
        load_ir(8'hFD);
        scan_dr(32, 0, d);
        chk("R6 user word", d[31:0], USER_V);
        load_ir(8'hFE);
        scan_dr(32, 0, d);
        chk("R6 identifier word", d[31:0], ID_V);
    endtask

    task automatic t_chain();
        logic [63:0] d;
        chain_tdo = 1;
        load_ir(8'h01);
        chk("R7 sample does not drive", drive_from_latch, 0);
        step(1, 0); step(0, 0);
        chk("R7 capture strobe", chain_capture, 1);
        step(0, 0);
        chk("R7 shift strobe", chain_shift, 1);
        chk("R7 tdo from chain", tdo, 1);
        step(1, 0); step(1, 0);
        chk("R7 update strobe", chain_update, 1);
        step(0, 0);
        load_ir(8'h00);
        chk("R7 external test drives", drive_from_latch, 1);
        scan_dr(2, 0, d);
        chk("R7 external test tdo from chain", d[1:0], 2'b11);
        chain_tdo = 0;
    endtask

    task automatic t_clamp();
        logic [63:0] d, cap;
        chain_tdo = 1;
        to_shift_ir();
        shift_bits(8, 64'hFA, cap);
        chk("R4 clamp not yet active in exit", clamp_en, 0);
        step(1, 0);
        chk("R4 clamp not yet active in update", clamp_en, 0);
        step(0, 0);
        chk("R8 clamp active", {clamp_en, drive_from_latch}, 2'b11);
        to_shift_dr();
        chk("R8 no chain shift under clamp", chain_shift, 0);
        shift_bits(2, 64'h1, d);
        finish_scan();
        chk("R8 clamp selects pass-through", d[1:0], 2'b10);
        chain_tdo = 0;
    endtask

    task automatic t_highz();
        logic [63:0] d;
        chain_tdo = 1;
        load_ir(8'hFC);
        chk("R9 float flag", {highz_en, clamp_en, drive_from_latch}, 3'b100);
        scan_dr(2, 64'h1, d);
        chk("R9 float selects pass-through", d[1:0], 2'b10);
        chain_tdo = 0;
    endtask

    task automatic t_config();
        logic [63:0] d, cap;
        to_shift_ir();
        shift_bits(8, 64'hEE, cap);
        step(1, 0);
        chk("R10 no request before idle", cfg_n, 1);
        step(0, 0);
        chk("R10 request low on idle entry", cfg_n, 0);
        step(0, 0);
        chk("R10 request one cycle long", cfg_n, 1);
        step(0, 0);
        chk("R10 request stays high in idle", cfg_n, 1);
        scan_dr(3, 64'h3, d);
        chk("R10 config selects pass-through", d[2:0], 3'b110);
        chk("R10 no repeat on re-entry", cfg_n, 1);
        load_ir(8'hEE);
        chk("R10 request on reload", cfg_n, 0);
        step(0, 0);
        chk("R10 reload pulse ends", cfg_n, 1);
    endtask

    task automatic t_edge();
        load_ir(8'hFE);
        chk("R11 oe low in idle", tdo_oe, 0);
        to_shift_dr();
        chk("R11 oe high in shift", tdo_oe, 1);
        chk("R11 first identifier bit", tdo, ID_V[0]);
        tms = 0; tdi = 0;
        @(posedge tck); #1;
        chk("R11 tdo held after rising edge", tdo, ID_V[0]);
        @(negedge tck); #1;
        chk("R11 tdo moves on falling edge", tdo, ID_V[1]);
        step(1, 0);
        chk("R11 oe low after shift", tdo_oe, 0);
        finish_scan();
    endtask

    initial begin
        sec_flag = 0; isc_flag = 0; chain_tdo = 0; trst_n = 0; tms = 1; tdi = 0;
        @(negedge tck); #1;
        t_reset();
        t_tms_reset();
        t_capture_ir();
        t_bypass(8'hFF);
        t_bypass(8'h5A);
        t_user();
        t_chain();
        t_clamp();
        t_highz();
        t_config();
        t_edge();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge tck);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule